// File: doc/BRIEF.md
# Four-Channel Register-Controlled PWM Generator

This block produces four independent pulse-width modulated outputs. Each channel owns a single 32-bit control word on a simple memory-mapped read/write bus. The word carries an enable flag, an 8-bit high-time count and a 13-bit clock divider. An enabled channel divides the input clock into step ticks and counts 256 steps per period. Its output stays high for as many steps as the high-time count says.

Software writes a channel word to start, retune or stop that channel. Retuning an enabled channel takes effect only at the next period boundary, so a running waveform never shows a truncated or stretched period. Writing zero stops the channel and drives its output low.

Top module: `pwm_quad`

## Requirements
- R1: After reset, all four control words read as zero and all four outputs are low.
- R2: Channel n's word is at byte address n*16, so address bits 5:4 select the channel and bits 3:0 must be zero. A write to any address with bits 3:0 nonzero changes nothing, and a read from such an address returns zero.
- R3: In a control word, bit 31 is the enable, bits 23:16 are the high-time count and bits 12:0 are the divider. A read returns the last value written with bits 30:24 and 15:13 forced to zero, so writing all ones reads back as 0x80FF1FFF.
- R4: A channel whose enable bit is clear drives a low output. The output is low in the cycle right after the clock edge that stores a word with bit 31 clear.
- R5: When the enable bit is stored into a disabled channel at edge k, the channel restarts from step 0 at edge k+1. Its output is high in the cycle after edge k+1 if the high-time count is nonzero.
- R6: Each step lasts divider+1 input clock cycles, and one period lasts 256 steps. A divider of 0 therefore gives one step per input clock.
- R7: The output is high while the step index within the period is below the high-time count. A count of 0 gives a constant low output, and a count of 255 gives 255 high steps and 1 low step per period.
- R8: A new high-time count or divider written to an enabled channel is used only from the next period boundary. The period in progress completes with the old settings.
- R9: The channels run independently. A write to one channel does not change another channel's word or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 6 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | PWM output, one bit per channel |

## Verification
A corrupted step or divider counter shows up on pwm_out as a shifted or resized high interval within a single period. That takes at most 256*(divider+1) cycles to surface, and only one step with a divider of 0. Settings that reload at the wrong time show up as a period whose high count matches neither the old nor the new value. A stale running flag shows up one cycle after a re-enable as an output that fails to go high. Wrong masking of the control word is visible on the next read of that channel.

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int CH = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_we,
  input  logic [$clog2(CH)+3:0]         bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic [CH-1:0]                 pwm_out
);
  localparam int SEL_W = $clog2(CH);
  localparam logic [31:0] WMASK = 32'h80FF_1FFF;

  logic [CH-1:0][31:0] ctrl;
  logic [CH-1:0]       run;
  logic [CH-1:0][7:0]  step, duty;
  logic [CH-1:0][12:0] pcnt, pre;
  logic [CH-1:0]       tick, wrap;

  wire             hit = (bus_addr[3:0] == 4'd0);
  wire [SEL_W-1:0] sel = bus_addr[SEL_W+3:4];

  assign bus_rdata = hit ? ctrl[sel] : 32'd0;

  always_comb begin
    for (int i = 0; i < CH; i++) begin
      tick[i]    = (pcnt[i] == pre[i]);
      wrap[i]    = tick[i] && (step[i] == 8'hFF);
      pwm_out[i] = run[i] && ctrl[i][31] && (step[i] < duty[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (bus_we && hit) ctrl[sel] <= bus_wdata & WMASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      step <= '0;
      duty <= '0;
      pcnt <= '0;
      pre  <= '0;
    end else begin
      for (int i = 0; i < CH; i++) begin
        if (!ctrl[i][31]) begin
          run[i] <= 1'b0;
        end else if (!run[i]) begin
          run[i]  <= 1'b1;
          step[i] <= 8'd0;
          pcnt[i] <= 13'd0;
          duty[i] <= ctrl[i][23:16];
          pre[i]  <= ctrl[i][12:0];
        end else if (tick[i]) begin
          pcnt[i] <= 13'd0;
          step[i] <= step[i] + 8'd1;
          if (wrap[i]) begin
            duty[i] <= ctrl[i][23:16];
            pre[i]  <= ctrl[i][12:0];
          end
        end else begin
          pcnt[i] <= pcnt[i] + 13'd1;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int CH = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_we,
  input logic [$clog2(CH)+3:0] bus_addr,
  input logic [31:0]           bus_wdata,
  input logic [CH-1:0][31:0]   ctrl,
  input logic [CH-1:0]         run,
  input logic [CH-1:0][7:0]    step,
  input logic [CH-1:0][7:0]    duty,
  input logic [CH-1:0]         tick,
  input logic [CH-1:0]         wrap,
  input logic [CH-1:0]         pwm_out
);
  localparam int SEL_W = $clog2(CH);

  assert_bad_addr_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr[3:0] != 4'd0) |=> $stable(ctrl));

  always @(posedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < CH; i++)
        assert_rsvd_zero_R3: assert ((ctrl[i] & 32'h7F00_E000) == 32'd0);
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_chk
    assert_off_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[3:0] == 4'd0 && bus_addr[SEL_W+3:4] == g && !bus_wdata[31])
      |=> !pwm_out[g]);

    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run[g]) |-> (step[g] == 8'd0));

    assert_step_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && ctrl[g][31] && !tick[g]) |=> $stable(step[g]));

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (run[g] && ctrl[g][31] && !wrap[g]) |=> $stable(duty[g]));
  end
endmodule

bind pwm_quad pwm_quad_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl(ctrl), .run(run), .step(step), .duty(duty),
  .tick(tick), .wrap(wrap), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_quad.sv
`timescale 1ns/1ps
module tb_pwm_quad;
  localparam logic [31:0] MASK = 32'h80FF_1FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  pwm_quad dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] m_ctrl [4];
  bit          m_run  [4];
  int          m_step [4], m_pcnt [4], m_duty [4], m_pre [4];
  int          hc [4];
  logic [5:0]  rd_addr = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_out(int i);
    return m_run[i] && m_ctrl[i][31] && (m_step[i] < m_duty[i]);
  endfunction

  function automatic logic [31:0] exp_rd(logic [5:0] a);
    return (a[3:0] == 4'd0) ? m_ctrl[a[5:4]] : 32'd0;
  endfunction

  function automatic void model_edge(bit we, logic [5:0] a, logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      if (!m_ctrl[i][31]) m_run[i] = 0;
      else if (!m_run[i]) begin
        m_run[i] = 1; m_step[i] = 0; m_pcnt[i] = 0;
        m_duty[i] = int'(m_ctrl[i][23:16]); m_pre[i] = int'(m_ctrl[i][12:0]);
      end else if (m_pcnt[i] == m_pre[i]) begin
        m_pcnt[i] = 0;
        if (m_step[i] == 255) begin
          m_step[i] = 0;
          m_duty[i] = int'(m_ctrl[i][23:16]); m_pre[i] = int'(m_ctrl[i][12:0]);
        end else m_step[i]++;
      end else m_pcnt[i]++;
    end
    if (we && a[3:0] == 4'd0) m_ctrl[a[5:4]] = d & MASK;
  endfunction

  task automatic cyc(input bit we, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge(we, a, d);
    #1;
    for (int i = 0; i < 4; i++) begin
      check(pwm_out[i] == exp_out(i), "R7 output vs model", 32'(pwm_out[i]), 32'(exp_out(i)));
      hc[i] += int'(pwm_out[i]);
    end
    check(bus_rdata == exp_rd(a), "R3 readback vs model", bus_rdata, exp_rd(a));
    bus_we = 0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, rd_addr, 32'd0);
  endtask

  task automatic wr(input int ch, input bit en, input int d, input int p);
    cyc(1'b1, 6'(ch * 16), {en, 7'd0, 8'(d), 3'd0, 13'(p)});
  endtask

  function automatic void clr_hc();
    for (int i = 0; i < 4; i++) hc[i] = 0;
  endfunction

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_ctrl[i] = 0; m_run[i] = 0; m_step[i] = 0; m_pcnt[i] = 0; m_duty[i] = 0; m_pre[i] = 0; hc[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      cyc(1'b0, 6'(c * 16), 32'd0);
      check(bus_rdata == 32'd0, "R1 reset word", bus_rdata, 32'd0);
      check(pwm_out == 4'd0, "R1 reset outputs", 32'(pwm_out), 32'd0);
    end

    // R3 mask on readback
    cyc(1'b1, 6'h30, 32'h7FFF_FFFF);
    cyc(1'b0, 6'h30, 32'd0);
    check(bus_rdata == 32'h00FF_1FFF, "R3 reserved bits", bus_rdata, 32'h00FF_1FFF);
    wr(3, 0, 0, 0);

    // R2 unaligned address ignored
    wr(1, 0, 8'h5A, 13'h0123);
    cyc(1'b1, 6'h14, 32'hFFFF_FFFF);
    cyc(1'b0, 6'h14, 32'd0);
    check(bus_rdata == 32'd0, "R2 unaligned read", bus_rdata, 32'd0);
    cyc(1'b0, 6'h10, 32'd0);
    check(bus_rdata == 32'h005A_0123, "R2 word unchanged", bus_rdata, 32'h005A_0123);
    check(pwm_out[1] == 1'b0, "R2 output unchanged", 32'(pwm_out[1]), 32'd0);
    wr(1, 0, 0, 0);

    // R7 duty 255, divider 0; R5 first step high
    wr(0, 1, 255, 0);
    clr_hc();
    idle(1);
    check(pwm_out[0] == 1'b1, "R5 high on first step", 32'(pwm_out[0]), 32'd1);
    idle(255);
    check(hc[0] == 255, "R7 duty 255 high count", 32'(hc[0]), 32'd255);

    // R4 disable drives low immediately
    wr(0, 0, 0, 0);
    check(pwm_out[0] == 1'b0, "R4 low after disable", 32'(pwm_out[0]), 32'd0);

    // R7 duty 0 constant low
    wr(2, 1, 0, 1);
    clr_hc(); idle(600);
    check(hc[2] == 0, "R7 duty 0 low", 32'(hc[2]), 32'd0);
    wr(2, 0, 0, 0);

    // R6 divider: duty 3, divider 2 -> 9 high per 768-cycle period
    wr(1, 1, 3, 2);
    clr_hc(); idle(768 * 2);
    check(hc[1] == 18, "R6 step length", 32'(hc[1]), 32'd18);
    wr(1, 0, 0, 0);

    // R6 max divider: duty 1, divider 8191 -> 8192 high cycles
    wr(3, 1, 1, 8191);
    clr_hc(); idle(8300);
    check(hc[3] == 8192, "R6 max divider", 32'(hc[3]), 32'd8192);
    wr(3, 0, 0, 0);

    // R8 shadowed update mid-period
    wr(1, 1, 10, 0);
    clr_hc(); idle(4);
    wr(1, 1, 200, 0);
    idle(507);
    check(hc[1] == 210, "R8 update at boundary", 32'(hc[1]), 32'd210);

    // R5 restart mid-period
    idle(37);
    wr(1, 0, 0, 0);
    wr(1, 1, 100, 0);
    clr_hc(); idle(256);
    check(hc[1] == 100, "R5 restart from zero", 32'(hc[1]), 32'd100);
    wr(1, 0, 0, 0);

    // R9 independence
    wr(0, 1, 64, 0);
    wr(2, 1, 128, 1);
    idle(1);
    clr_hc(); idle(512);
    check(hc[0] == 128, "R9 channel 0 count", 32'(hc[0]), 32'd128);
    check(hc[2] == 256, "R9 channel 2 count", 32'(hc[2]), 32'd256);
    check(hc[1] == 0 && hc[3] == 0, "R9 idle channels low", 32'(hc[1] + hc[3]), 32'd0);

    // constrained random traffic checked against the model
    void'($urandom(32'd1234));
    for (int n = 0; n < 1500; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 3) begin
        logic [31:0] d = $urandom;
        d[12:0] = 13'($urandom_range(0, 3));
        if (r == 0) d[23:16] = ($urandom_range(0, 1) != 0) ? 8'hFF : 8'h00;
        cyc(1'b1, 6'($urandom_range(0, 3) * 16), d);
      end else if (r == 3) begin
        cyc(1'b1, 6'($urandom_range(0, 63)), $urandom);
      end else begin
        rd_addr = 6'($urandom_range(0, 63));
        idle($urandom_range(1, 40));
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule